// File: doc/BRIEF.md
# UART Receiver Wakeup Controller

This block gives an asynchronous serial receiver a sleep mode for multidrop links, where only the addressed node needs to react. It sits beside the receive shift path. It watches the sampled line level, the one-per-bit-time strobe and the start-bit strobe. From these it tracks the position of each bit inside the current character and counts consecutive idle bit times.

Software puts the receiver to sleep with a single-cycle request. The block then wakes on its own, by one of two selectable methods. In idle-line mode it wakes after one full character time of continuous idle. In address-mark mode it wakes on a character whose most significant bit is 1. While the receiver sleeps, the receive-full, idle and framing-error strobes are held off. The idle period that wakes the receiver is also held off, so only the following character raises a flag.

All result strobes are registered and appear one clock after the bit strobe that caused them.

Top module: `uart_rx_wake`

## Requirements
- R1: A one-cycle `sleepReq` sets `asleep` on the next clock. After reset, `asleep`, `fullSet`, `idleSet`, `errSet` and `wakeEvt` are all 0.
- R2: With `wakeAddr`=0, a sleeping receiver wakes after one full character time of idle line: 10 consecutive 1 bit times when `nineBit`=0, or 11 when `nineBit`=1. The wake raises `wakeEvt` for one cycle and clears `asleep`.
- R3: With `idleType`=0, idle counting restarts at the start bit, so the stop bit and trailing 1 data bits count toward the character time.
- R4: With `idleType`=1, idle counting begins only after the stop bit time; the stop bit itself and the data bits do not count.
- R5: The idle period that wakes the receiver raises no `idleSet` pulse. The next character then raises `fullSet` normally.
- R6: With `wakeAddr`=1, a character whose MSB is 1 wakes the receiver. The MSB is the 8th data bit after the start bit (data bit 7, LSB first) when `nineBit`=0, and the 9th (data bit 8) when `nineBit`=1. `asleep` clears before the stop bit, and that character raises `fullSet`.
- R7: While asleep, a character that does not wake the receiver raises none of `fullSet`, `idleSet` or `errSet`.
- R8: With `wakeAddr`=1, idle line time does not wake the receiver.
- R9: While awake, each character raises `fullSet` at its stop bit, plus `errSet` if the stop bit is 0. After a received character, `idleSet` pulses once when the idle character time completes.
- R10: When an automatic wake and `sleepReq` occur in the same cycle, the wake wins and `asleep` ends 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | One pulse per bit time at the sample point |
| lineBit | input | 1 | Sampled line level, valid with bitTick |
| startSeen | input | 1 | Marks the bitTick that sampled a valid start bit |
| wakeAddr | input | 1 | Wake method: 0 idle line, 1 address mark |
| idleType | input | 1 | 0 count idle from start bit, 1 count only after stop bit |
| nineBit | input | 1 | 0 eight data bits, 1 nine data bits |
| sleepReq | input | 1 | Software request to put the receiver to sleep |
| asleep | output | 1 | Receiver sleep state |
| wakeEvt | output | 1 | One-cycle pulse on automatic wake |
| fullSet | output | 1 | Gated receive-full set pulse |
| idleSet | output | 1 | Gated idle-detected set pulse |
| errSet | output | 1 | Gated framing-error set pulse |

## Verification
The bound assertions check the gating rules on every cycle:
- no receive-full or framing-error pulse may follow a sleeping cycle;
- a wake never carries an idle pulse;
- a sleep request always takes effect;
- receive-full and idle never coincide.

The exact idle bit counts need the bench's frame scenarios to show them: the 10 versus 11 bit thresholds, and the different start points of the two idle types. The same holds for the MSB position in each data length, the wake landing before the stop bit, and the ordering of wake, full and idle events.

// File: rtl/uart_rx_wake_pkg.sv
package uart_rx_wake_pkg;
  // strobes from the datapath to the control
  typedef struct packed {
    logic idleHit;   // idle character time just completed
    logic msbHit;    // MSB sampled as 1
    logic frameEnd;  // stop bit sampled
    logic stopBad;   // stop bit sampled as 0
  } rxEvt_t;
endpackage

// File: rtl/uart_rx_wake_dp.sv
module uart_rx_wake_dp
  import uart_rx_wake_pkg::*;
#(
  parameter int SHORT_BITS = 8,
  parameter int LONG_BITS  = 9,
  parameter int CNT_W      = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   bitTick,
  input  logic   lineBit,
  input  logic   startSeen,
  input  logic   idleType,
  input  logic   nineBit,
  output rxEvt_t evt
);
  localparam logic [CNT_W-1:0] MSB_SHORT = CNT_W'(SHORT_BITS);
  localparam logic [CNT_W-1:0] MSB_LONG  = CNT_W'(LONG_BITS);

  logic             inFrame;
  logic [CNT_W-1:0] pos;
  logic [CNT_W-1:0] idleCnt;
  logic [CNT_W-1:0] msbIdx, stopIdx, idleTarget;
  logic             countEn;

  always_comb begin
    msbIdx     = nineBit ? MSB_LONG : MSB_SHORT;
    stopIdx    = msbIdx + CNT_W'(1);
    idleTarget = msbIdx + CNT_W'(2);
    // idle type 1 holds the count for the whole frame including stop
    countEn    = idleType ? !inFrame : 1'b1;
  end

  // bit position within the current character
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inFrame <= 1'b0;
      pos     <= '0;
    end else if (bitTick) begin
      if (startSeen) begin
        inFrame <= 1'b1;
        pos     <= CNT_W'(1);
      end else if (inFrame) begin
        if (pos == stopIdx) inFrame <= 1'b0;
        else                pos     <= pos + CNT_W'(1);
      end
    end
  end

  // consecutive idle bit counter, saturating at the target
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idleCnt <= '0;
    end else if (bitTick) begin
      if (!lineBit || startSeen)
        idleCnt <= '0;
      else if (countEn && idleCnt != idleTarget)
        idleCnt <= idleCnt + CNT_W'(1);
    end
  end

  always_comb begin
    evt.msbHit   = bitTick && inFrame && !startSeen && pos == msbIdx && lineBit;
    evt.frameEnd = bitTick && inFrame && !startSeen && pos == stopIdx;
    evt.stopBad  = evt.frameEnd && !lineBit;
    evt.idleHit  = bitTick && lineBit && !startSeen && countEn &&
                   idleCnt == idleTarget - CNT_W'(1);
  end
endmodule

// File: rtl/uart_rx_wake_ctl.sv
module uart_rx_wake_ctl
  import uart_rx_wake_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  rxEvt_t evt,
  input  logic   wakeAddr,
  input  logic   sleepReq,
  output logic   asleep,
  output logic   wakeEvt,
  output logic   fullSet,
  output logic   idleSet,
  output logic   errSet
);
  logic idleArmed;
  logic wakeNow;

  always_comb wakeNow = asleep && (wakeAddr ? evt.msbHit : evt.idleHit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      asleep    <= 1'b0;
      idleArmed <= 1'b0;
      wakeEvt   <= 1'b0;
      fullSet   <= 1'b0;
      idleSet   <= 1'b0;
      errSet    <= 1'b0;
    end else begin
      // automatic clear outranks the software set
      if (wakeNow)       asleep <= 1'b0;
      else if (sleepReq) asleep <= 1'b1;

      if (evt.frameEnd && !asleep) idleArmed <= 1'b1;
      else if (evt.idleHit)        idleArmed <= 1'b0;

      wakeEvt <= wakeNow;
      fullSet <= evt.frameEnd && !asleep;
      errSet  <= evt.stopBad && !asleep;
      idleSet <= evt.idleHit && idleArmed && !asleep;
    end
  end
endmodule

// File: rtl/uart_rx_wake.sv
module uart_rx_wake
  import uart_rx_wake_pkg::*;
#(
  parameter int SHORT_BITS = 8,
  parameter int LONG_BITS  = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bitTick,
  input  logic lineBit,
  input  logic startSeen,
  input  logic wakeAddr,
  input  logic idleType,
  input  logic nineBit,
  input  logic sleepReq,
  output logic asleep,
  output logic wakeEvt,
  output logic fullSet,
  output logic idleSet,
  output logic errSet
);
  localparam int CNT_W = $clog2(LONG_BITS + 3);

  rxEvt_t evt;

  uart_rx_wake_dp #(
    .SHORT_BITS(SHORT_BITS), .LONG_BITS(LONG_BITS), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .bitTick(bitTick), .lineBit(lineBit),
    .startSeen(startSeen), .idleType(idleType), .nineBit(nineBit), .evt(evt)
  );

  uart_rx_wake_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .evt(evt), .wakeAddr(wakeAddr),
    .sleepReq(sleepReq), .asleep(asleep), .wakeEvt(wakeEvt),
    .fullSet(fullSet), .idleSet(idleSet), .errSet(errSet)
  );
endmodule

// File: rtl/uart_rx_wake_chk.sv
module uart_rx_wake_chk (
  input logic clk,
  input logic rst_n,
  input logic wakeAddr,
  input logic sleepReq,
  input logic asleep,
  input logic wakeEvt,
  input logic fullSet,
  input logic idleSet,
  input logic errSet
);
  // R1: a sleep request while awake always lands
  a_r1_sleep_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sleepReq) && !$past(asleep)) |-> asleep);

  // R7: no receive-full or error pulse follows a sleeping cycle
  a_r7_no_full_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    fullSet |-> !$past(asleep));
  a_r7_no_err_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    errSet |-> !$past(asleep));

  // R5: the waking idle character carries no idle pulse
  a_r5_no_idle_on_wake: assert property (@(posedge clk) disable iff (!rst_n)
    wakeEvt |-> !idleSet);

  // R10: a wake leaves the receiver awake even against a sleep request
  a_r10_wake_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wakeEvt |-> (!asleep && $past(asleep)));

  // R9: receive-full and idle never coincide
  a_r9_full_idle_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fullSet, idleSet}));
endmodule

bind uart_rx_wake uart_rx_wake_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wakeAddr(wakeAddr), .sleepReq(sleepReq),
  .asleep(asleep), .wakeEvt(wakeEvt), .fullSet(fullSet),
  .idleSet(idleSet), .errSet(errSet)
);

// File: tb/sim_uart_rx_wake.sv
module sim_uart_rx_wake;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bitTick = 1'b0, lineBit = 1'b1, startSeen = 1'b0;
  logic wakeAddr = 1'b0, idleType = 1'b1, nineBit = 1'b0, sleepReq = 1'b0;
  logic asleep, wakeEvt, fullSet, idleSet, errSet;

  localparam int EV_WAKE = 1, EV_FULL = 2, EV_ERR = 3, EV_IDLE = 4;

  int nChk = 0, nFail = 0;
  int seenIdle = 0;
  int expQ[$];
  bit finished = 1'b0;

  always #5 clk = ~clk;

  uart_rx_wake u0 (
    .clk(clk), .rst_n(rst_n), .bitTick(bitTick), .lineBit(lineBit),
    .startSeen(startSeen), .wakeAddr(wakeAddr), .idleType(idleType),
    .nineBit(nineBit), .sleepReq(sleepReq), .asleep(asleep),
    .wakeEvt(wakeEvt), .fullSet(fullSet), .idleSet(idleSet), .errSet(errSet)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic popCmp(input int kind);
    int exp;
    if (expQ.size() == 0) exp = 0;
    else exp = expQ.pop_front();
    chk("R9 event order (R2 R5 R6 R7 R8)", kind, exp);
  endtask

  // monitor: outputs are registered, sample on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (wakeEvt) popCmp(EV_WAKE);
      if (fullSet) popCmp(EV_FULL);
      if (errSet)  popCmp(EV_ERR);
      if (idleSet) begin popCmp(EV_IDLE); seenIdle++; end
    end
  end

  task automatic tick(input logic b, input logic st, input logic sreq);
    @(negedge clk);
    bitTick = 1'b1; lineBit = b; startSeen = st; sleepReq = sreq;
    @(negedge clk);
    bitTick = 1'b0; startSeen = 1'b0; sleepReq = 1'b0; lineBit = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic idleTicks(input int n);
    for (int i = 0; i < n; i++) tick(1'b1, 1'b0, 1'b0);
  endtask

  task automatic sendFrame(input logic [8:0] data, input logic stopBit,
                           input bit midCheck, input int midExp);
    tick(1'b0, 1'b1, 1'b0);
    for (int i = 0; i < (nineBit ? 9 : 8); i++) tick(data[i], 1'b0, 1'b0);
    if (midCheck) chk("R6 asleep cleared before stop", int'(asleep), midExp);
    tick(stopBit, 1'b0, 1'b0);
  endtask

  task automatic goSleep();
    @(negedge clk); sleepReq = 1'b1;
    @(negedge clk); sleepReq = 1'b0;
    chk("R1 sleep request sets asleep", int'(asleep), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state (covered under R1)
    chk("R1 reset asleep", int'(asleep), 0);
    chk("R1 reset strobes", int'({wakeEvt, fullSet, idleSet, errSet}), 0);

    // awake, 8-bit, idle type 1: stop bit not counted
    expQ.push_back(EV_FULL);
    sendFrame(9'h035, 1'b1, 0, 0);
    idleTicks(9);
    chk("R4 no idle after 9 ticks past stop", seenIdle, 0);
    expQ.push_back(EV_IDLE);
    idleTicks(1);
    chk("R9 idle after 10 ticks past stop", seenIdle, 1);

    // idle type 0: stop bit and trailing ones count
    idleType = 1'b0;
    expQ.push_back(EV_FULL);
    sendFrame(9'h0F0, 1'b1, 0, 0);
    idleTicks(4);
    chk("R3 not yet idle", seenIdle, 1);
    expQ.push_back(EV_IDLE);
    idleTicks(1);
    chk("R3 idle counts trailing ones and stop", seenIdle, 2);
    idleType = 1'b1;

    // idle-line wake
    goSleep();
    sendFrame(9'h0A5, 1'b1, 0, 0);
    chk("R7 data char dropped while asleep", int'(asleep), 1);
    idleTicks(9);
    chk("R2 still asleep after 9 idle ticks", int'(asleep), 1);
    expQ.push_back(EV_WAKE);
    idleTicks(1);
    chk("R2 woken after 10 idle ticks", int'(asleep), 0);
    chk("R5 no idle flag on waking idle", seenIdle, 2);
    expQ.push_back(EV_FULL);
    sendFrame(9'h011, 1'b1, 0, 0);
    expQ.push_back(EV_IDLE);
    idleTicks(10);
    chk("R5 next char then idle flagged", seenIdle, 3);

    // address mark, 8-bit
    wakeAddr = 1'b1;
    goSleep();
    sendFrame(9'h012, 1'b1, 0, 0);
    idleTicks(12);
    chk("R8 idle does not wake in address mode", int'(asleep), 1);
    chk("R7 no idle flag while asleep", seenIdle, 3);
    expQ.push_back(EV_WAKE);
    expQ.push_back(EV_FULL);
    sendFrame(9'h085, 1'b1, 1, 0);
    expQ.push_back(EV_IDLE);
    idleTicks(10);

    // address mark, 9-bit
    nineBit = 1'b1;
    goSleep();
    sendFrame(9'h080, 1'b1, 0, 0);
    chk("R6 bit 7 is not the MSB in 9-bit mode", int'(asleep), 1);
    expQ.push_back(EV_WAKE);
    expQ.push_back(EV_FULL);
    sendFrame(9'h101, 1'b1, 1, 0);
    idleTicks(10);
    chk("R2 9-bit needs 11 idle ticks", seenIdle, 4);
    expQ.push_back(EV_IDLE);
    idleTicks(1);
    chk("R2 9-bit idle after 11 ticks", seenIdle, 5);

    // framing error awake and asleep
    nineBit = 1'b0; wakeAddr = 1'b0;
    expQ.push_back(EV_FULL);
    expQ.push_back(EV_ERR);
    sendFrame(9'h03C, 1'b0, 0, 0);
    expQ.push_back(EV_IDLE);
    idleTicks(10);
    goSleep();
    sendFrame(9'h055, 1'b0, 0, 0);
    chk("R7 error suppressed while asleep", int'(asleep), 1);

    // wake and sleep request in the same cycle
    idleTicks(9);
    expQ.push_back(EV_WAKE);
    tick(1'b1, 1'b0, 1'b1);
    chk("R10 wake outranks sleep request", int'(asleep), 0);

    repeat (4) @(negedge clk);
    chk("R9 all expected events seen", expQ.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChk++; nFail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end
endmodule